// File: doc/BRIEF.md
# Column Conditional-Reset Decision Unit

This unit sits at the top of one pixel column of a wide-dynamic-range image sensor. Each frame's integration time is split into a series of checkpoints. At each checkpoint the rows are scanned one after another. For each row, the column comparator reports whether the selected pixel has dropped below the saturation threshold. The unit combines that report with the reset decision stored for the same pixel at the previous checkpoint. It then drives the column reset line for one cycle and records the new decision in a per-pixel bit store.

The first checkpoint of a frame is flagged by a first-check input. On that checkpoint the previous decision is taken as 1, so only the comparator result counts. In global-shutter operation each decision is also offered to the pixel's own one-bit hold through a write pulse. After integration the stored bits of a row are read out in the same slot as that row's analog value. They form the exponent that scales the mantissa. If a first-check scan arrives while a frame is still open, the whole store is wiped before the new bit is written.

Top module: `colrst_decider`

## Requirements
- R1: A scan with `sat_in` = 0 (level not below threshold) always yields decision 0: no column reset, and a 0 is stored.
- R2: A scan with `first_check` = 1 treats the previous decision as 1. The decision equals `sat_in` and is stored as bit 0 of the row's entry.
- R3: A scan at checkpoint k ≥ 1 with `first_check` = 0 yields `sat_in` AND bit k−1 of the same row's entry. The result is stored as bit k.
- R4: The decision is written to the store on the same clock edge that drives `col_rst`. A scan of any row, or of the same row at the next checkpoint, may follow on the very next cycle.
- R5: `col_rst` is high for exactly the cycle after a scan whose decision is 1. It is low after a cycle without a scan.
- R6: `pix_rst_en` is high only when `col_rst` and `row_rst_in` are both high.
- R7: With `global_mode` = 1, each scan gives a one-cycle `hold_wr` pulse with `hold_bit` equal to the decision. With `global_mode` = 0, `hold_wr` stays low.
- R8: `rd_en` with `rd_row` gives, on the next cycle, `rd_valid` = 1 and `rd_bits` holding that row's entry, where bit k is the decision of checkpoint k.
- R9: A later-check scan opens a frame. Reading row ROWS−1 closes it. A first-check scan while a frame is open clears every entry before writing its own bit. A first-check scan with no open frame clears nothing.
- R10: After reset all outputs are 0 and every stored entry reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scan_valid | input | 1 | A row is presented for a saturation check this cycle |
| first_check | input | 1 | This scan belongs to the first checkpoint of the frame |
| check_idx | input | $clog2(CHECKS) | Checkpoint number of this scan |
| scan_row | input | $clog2(ROWS) | Row being scanned |
| sat_in | input | 1 | Comparator result, 1 when the pixel level is below threshold |
| global_mode | input | 1 | 1 for global shutter, 0 for rolling shutter |
| row_rst_in | input | 1 | Row reset line from the row logic |
| col_rst | output | 1 | Column reset line, the registered decision |
| pix_rst_en | output | 1 | Reset enable reaching the pixel (column AND row line) |
| hold_wr | output | 1 | Write strobe for the pixel's local decision hold |
| hold_bit | output | 1 | Decision value for the local hold |
| rd_en | input | 1 | Request the stored bits of a row |
| rd_row | input | $clog2(ROWS) | Row to read |
| rd_valid | output | 1 | `rd_bits` is valid |
| rd_bits | output | CHECKS | Stored decisions of the row, bit k for checkpoint k |

## Verification
A table walks several rows through all checkpoints in an interleaved order. Some rows saturate at every checkpoint and some stop part way. One row saturates at a later checkpoint after a 0 was stored earlier, which tells the AND with the stored bit apart from a plain copy of the comparator. Readback of every touched row then checks each bit position against its checkpoint. Directed cases use a low row reset line and rolling mode to separate `col_rst` from `pix_rst_en` and `hold_wr`. Further cases issue a first-check scan with the frame closed and then with it open, which distinguishes a real wipe from stale data left in place.

// File: rtl/crd_pkg.sv
// Shared types for the column conditional-reset decision unit.
// Assumes nothing beyond the scan kinds used by the top level.
package crd_pkg;

    typedef enum logic [1:0] {
        SCAN_NONE  = 2'd0,
        SCAN_FIRST = 2'd1,
        SCAN_LATER = 2'd2
    } scan_kind_e;

    // Classify the current cycle from the scan strobes.
    function automatic scan_kind_e classify(input logic valid, input logic first);
        if (!valid)     return SCAN_NONE;
        else if (first) return SCAN_FIRST;
        else            return SCAN_LATER;
    endfunction

endpackage

// File: rtl/crd_prev_sel.sv
// Previous-decision latch source and AND gate.
// Picks the stored bit of the prior checkpoint, or 1 on a first check
// (or checkpoint 0), and forms the new reset decision.
// Assumes CHECKS >= 2 and row_bits is the scanned row's current entry.
module crd_prev_sel
    import crd_pkg::*;
#(
    parameter int CHECKS = 4,
    localparam int CW = $clog2(CHECKS)
) (
    input  scan_kind_e        kind,
    input  logic [CW-1:0]     idx,
    input  logic [CHECKS-1:0] row_bits,
    input  logic              sat,
    output logic [CW-1:0]     wr_idx,
    output logic              decision
);

    logic prev;

    // Select the previous-checkpoint bit, forced to 1 at frame start.
    always_comb begin
        prev = 1'b1;
        for (int k = 1; k < CHECKS; k++) begin
            if (idx == CW'(k)) prev = row_bits[k-1];
        end
        if (kind == SCAN_FIRST) prev = 1'b1;
    end

    // Decision and target bit position.
    always_comb begin
        decision = sat & prev;
        wr_idx   = (kind == SCAN_FIRST) ? '0 : idx;
    end

endmodule

// File: rtl/crd_bit_store.sv
// Per-pixel decision store: ROWS entries of CHECKS bits.
// One bit write per cycle, a whole-array clear that the same cycle's
// write overrides for its bit, a combinational lookup port for the
// scan path and a registered readout port.
// Assumes ROWS and CHECKS are powers of two.
module crd_bit_store #(
    parameter int ROWS   = 8,
    parameter int CHECKS = 4,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(CHECKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [RW-1:0]     wr_row,
    input  logic [CW-1:0]     wr_idx,
    input  logic              wr_bit,
    input  logic [RW-1:0]     look_row,
    output logic [CHECKS-1:0] look_bits,
    input  logic              rd_en,
    input  logic [RW-1:0]     rd_row,
    output logic              rd_valid,
    output logic [CHECKS-1:0] rd_bits
);

    logic [ROWS*CHECKS-1:0] flat;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic [CHECKS-1:0] row_q;
        logic [CHECKS-1:0] row_nx;

        // Next value: optional wipe, then this row's bit write.
        always_comb begin
            row_nx = clr ? '0 : row_q;
            if (wr_en && wr_row == RW'(r)) row_nx[wr_idx] = wr_bit;
        end

        // Row entry register.
        always_ff @(posedge clk) begin
            if (!rst_n) row_q <= '0;
            else        row_q <= row_nx;
        end

        assign flat[r*CHECKS +: CHECKS] = row_q;
    end

    // Lookup for the previous-decision latch.
    assign look_bits = flat[int'(look_row)*CHECKS +: CHECKS];

    // Registered readout alongside the analog value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_bits  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_bits <= flat[int'(rd_row)*CHECKS +: CHECKS];
        end
    end

    AST_RD_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid); // R8

    AST_RD_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid); // R8

endmodule

// File: rtl/colrst_decider.sv
// Column conditional-reset decision unit.
// Per scanned row: decision = comparator result AND previous stored
// decision (1 on the first check), written to the bit store and driven
// onto the column reset line on the same edge.  Tracks an open frame so
// that a first-check scan in mid-frame wipes the store.
// Assumes one scan per cycle and ROWS, CHECKS powers of two.
module colrst_decider
    import crd_pkg::*;
#(
    parameter int ROWS   = 8,
    parameter int CHECKS = 4,
    localparam int RW = $clog2(ROWS),
    localparam int CW = $clog2(CHECKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_valid,
    input  logic              first_check,
    input  logic [CW-1:0]     check_idx,
    input  logic [RW-1:0]     scan_row,
    input  logic              sat_in,
    input  logic              global_mode,
    input  logic              row_rst_in,
    output logic              col_rst,
    output logic              pix_rst_en,
    output logic              hold_wr,
    output logic              hold_bit,
    input  logic              rd_en,
    input  logic [RW-1:0]     rd_row,
    output logic              rd_valid,
    output logic [CHECKS-1:0] rd_bits
);

    scan_kind_e        kind;
    logic [CHECKS-1:0] look_bits;
    logic [CW-1:0]     wr_idx;
    logic              decision;
    logic              frame_open_q;
    logic              wipe;
    logic              col_rst_q;
    logic              hold_wr_q;
    logic              hold_bit_q;

    assign kind = classify(scan_valid, first_check);
    assign wipe = (kind == SCAN_FIRST) && frame_open_q;

    crd_prev_sel #(.CHECKS(CHECKS)) i_prev (
        .kind     (kind),
        .idx      (check_idx),
        .row_bits (look_bits),
        .sat      (sat_in),
        .wr_idx   (wr_idx),
        .decision (decision)
    );

    crd_bit_store #(.ROWS(ROWS), .CHECKS(CHECKS)) i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (wipe),
        .wr_en     (scan_valid),
        .wr_row    (scan_row),
        .wr_idx    (wr_idx),
        .wr_bit    (decision),
        .look_row  (scan_row),
        .look_bits (look_bits),
        .rd_en     (rd_en),
        .rd_row    (rd_row),
        .rd_valid  (rd_valid),
        .rd_bits   (rd_bits)
    );

    // Frame tracking: opened by a later check, closed by reading the last row.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 frame_open_q <= 1'b0;
        else if (kind == SCAN_LATER)                frame_open_q <= 1'b1;
        else if (rd_en && rd_row == RW'(ROWS - 1))  frame_open_q <= 1'b0;
        else if (wipe)                              frame_open_q <= 1'b0;
    end

    // Column reset line and local-hold strobe, same edge as the store write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_rst_q  <= 1'b0;
            hold_wr_q  <= 1'b0;
            hold_bit_q <= 1'b0;
        end else begin
            col_rst_q  <= scan_valid & decision;
            hold_wr_q  <= scan_valid & global_mode;
            hold_bit_q <= scan_valid & decision;
        end
    end

    assign col_rst    = col_rst_q;
    assign hold_wr    = hold_wr_q;
    assign hold_bit   = hold_bit_q;
    assign pix_rst_en = col_rst_q & row_rst_in;

    AST_NO_SAT_NO_RST: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !sat_in) |=> !col_rst); // R1

    AST_FIRST_FOLLOWS_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && first_check) |=> (col_rst == $past(sat_in))); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_valid |=> !col_rst); // R5

    AST_ROLLING_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_valid && !global_mode) |=> !hold_wr); // R7

endmodule

// File: tb/test_colrst_decider.sv
module test_colrst_decider;

    localparam int ROWS   = 8;
    localparam int CHECKS = 4;
    localparam int NV     = 15;

    // Entry: {first, idx[1:0], row[2:0], sat, expected decision}
    localparam logic [7:0] VEC [NV] = '{
        8'b1_00_000_1_1, 8'b1_00_001_0_0, 8'b1_00_010_1_1, 8'b1_00_011_1_1,
        8'b1_00_111_1_1, 8'b0_01_000_1_1, 8'b0_01_001_1_0, 8'b0_01_010_0_0,
        8'b0_01_011_1_1, 8'b0_10_000_0_0, 8'b0_10_001_1_0, 8'b0_10_010_1_0,
        8'b0_10_011_1_1, 8'b0_11_000_1_0, 8'b0_11_011_1_1
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scan_valid = 1'b0, first_check = 1'b0, sat_in = 1'b0;
    logic [1:0] check_idx = '0;
    logic [2:0] scan_row = '0, rd_row = '0;
    logic       global_mode = 1'b0, row_rst_in = 1'b0, rd_en = 1'b0;
    logic       col_rst, pix_rst_en, hold_wr, hold_bit, rd_valid;
    logic [3:0] rd_bits;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    colrst_decider #(.ROWS(ROWS), .CHECKS(CHECKS)) i_colrst_decider (
        .clk(clk), .rst_n(rst_n), .scan_valid(scan_valid), .first_check(first_check),
        .check_idx(check_idx), .scan_row(scan_row), .sat_in(sat_in),
        .global_mode(global_mode), .row_rst_in(row_rst_in), .col_rst(col_rst),
        .pix_rst_en(pix_rst_en), .hold_wr(hold_wr), .hold_bit(hold_bit),
        .rd_en(rd_en), .rd_row(rd_row), .rd_valid(rd_valid), .rd_bits(rd_bits)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One scan cycle; returns at the next falling edge with outputs settled.
    task automatic scan(input logic f, input logic [1:0] idx, input logic [2:0] row,
                        input logic s);
        scan_valid = 1'b1; first_check = f; check_idx = idx; scan_row = row; sat_in = s;
        @(negedge clk);
        scan_valid = 1'b0; first_check = 1'b0;
    endtask

    task automatic rd(input logic [2:0] row, input logic [3:0] exp, input string tag);
        rd_en = 1'b1; rd_row = row;
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " rd_valid"}, {7'd0, rd_valid}, 8'd1);
        chk({tag, " rd_bits"}, {4'd0, rd_bits}, {4'd0, exp});
    endtask

    initial begin
        #400000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        chk("R10 col_rst", {7'd0, col_rst}, 8'd0);
        chk("R10 hold_wr", {7'd0, hold_wr}, 8'd0);
        rd(3'd2, 4'b0000, "R10 empty store");

        // R6 / R7: row line low, rolling mode
        global_mode = 1'b0; row_rst_in = 1'b0;
        scan(1'b1, 2'd0, 3'd4, 1'b1);
        chk("R6 col_rst set", {7'd0, col_rst}, 8'd1);
        chk("R6 pix_rst_en gated", {7'd0, pix_rst_en}, 8'd0);
        chk("R7 rolling hold_wr", {7'd0, hold_wr}, 8'd0);
        @(negedge clk);
        chk("R5 idle col_rst", {7'd0, col_rst}, 8'd0);

        // Table: R1 R2 R3 R4 R5 R7 in global mode, row line high
        global_mode = 1'b1; row_rst_in = 1'b1;
        for (int i = 0; i < NV; i++) begin
            scan(VEC[i][7], VEC[i][6:5], VEC[i][4:2], VEC[i][1]);
            chk($sformatf("R3 vec%0d col_rst", i), {7'd0, col_rst}, {7'd0, VEC[i][0]});
            chk($sformatf("R6 vec%0d pix_rst_en", i), {7'd0, pix_rst_en}, {7'd0, VEC[i][0]});
            chk($sformatf("R7 vec%0d hold", i), {6'd0, hold_wr, hold_bit}, {6'd0, 1'b1, VEC[i][0]});
        end

        // R8 / R4: readback, bit k = checkpoint k
        rd(3'd0, 4'b0011, "R8 row0");
        rd(3'd1, 4'b0000, "R1 row1");
        rd(3'd2, 4'b0001, "R3 row2");
        rd(3'd3, 4'b1111, "R4 row3");
        rd(3'd7, 4'b0001, "R2 row7");

        // R9: first check with frame closed keeps data
        scan(1'b1, 2'd0, 3'd0, 1'b1);
        chk("R2 new frame col_rst", {7'd0, col_rst}, 8'd1);
        rd(3'd3, 4'b1111, "R9 no wipe");

        // R9: open the frame, then a first check wipes it
        scan(1'b0, 2'd1, 3'd0, 1'b0);
        chk("R1 later no sat", {7'd0, col_rst}, 8'd0);
        scan(1'b1, 2'd0, 3'd5, 1'b0);
        rd(3'd3, 4'b0000, "R9 wiped row3");
        rd(3'd0, 4'b0000, "R9 wiped row0");
        rd(3'd4, 4'b0000, "R9 wiped row4");

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule